// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block sits beside a processor core and decides which interrupt the core should take next. It gathers up to 32 external request lines and one non-maskable line. Each external line has its own two-bit priority, an enable bit, and a capture mode that is either level or pulse. A line that has been captured stays pending until the core accepts it. The winner is offered to the core as a request flag, an exception number and a priority. The core answers with an accept strobe or an exception-return strobe. Software sets up the lines through a small register port: a write takes effect at the clock edge, and read data comes back one cycle after the address is presented.

A three-state machine drives the core-side offer. The states are `ST_QUIET` (nothing offered), `ST_OFFER_IRQ` (an external line is offered) and `ST_OFFER_NMI` (the non-maskable line is offered). The transitions are:
- raise: from `ST_QUIET` to an offer state, when a candidate exists.
- retarget: from `ST_OFFER_IRQ` back to `ST_OFFER_IRQ` with a new line, when the best candidate changes.
- escalate: from `ST_OFFER_IRQ` to `ST_OFFER_NMI`, when the non-maskable line arrives.
- withdraw: from `ST_OFFER_IRQ` to `ST_QUIET`, when no candidate remains.
- accept: from either offer state to `ST_QUIET`, on `core_ack`.

After an accept the offer always drops for one cycle. This lets the new running priority take effect before the next choice is made.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every pending, active, enable, mode and priority bit is clear, `core_req` is 0, and `core_excnum` and `core_prio` are 0.
- R2: Register map, by word address:
  - 0: enable.
  - 1: set-pending on write; reads return the pending bits.
  - 2: clear-pending on write; reads return the pending bits.
  - 3: active bits (read only).
  - 4: mode (1 means pulse).
  - 8: priorities of lines 0-15, two bits per line, line i at bits [2i+1:2i].
  - 9: priorities of lines 16-31, in the same layout.

  Read data appears one cycle after the address. Bits for lines that do not exist read 0.
- R3: Among pending, enabled lines, the lowest priority value wins, and on equal priority the lowest line index wins. A disabled line is never offered, but its pending bit is kept.
- R4: The non-maskable line is captured on its rising edge. It cannot be disabled and beats any external line. It is offered as exception number 2 with priority 0. While it is active, nothing is offered.
- R5: An external line is offered only if its priority value is strictly lower than the running priority. The running priority is the lowest priority value among the active lines, or 4 when no line is active.
- R6: Latency is fixed. Pending is captured at the first clock edge after an input change or register write, and the offer appears at the next edge.
- R7: An accept moves the offered source from pending to active, and `core_req` is 0 in the cycle that follows.
- R8: An exception return ends the non-maskable handler if it is active. Otherwise it ends the active line with the lowest priority value.
- R9: In pulse mode, a rising edge sets pending, which holds until it is accepted or cleared. A rising edge while the same line is active sets pending again.
- R10: In level mode, pending is set at every edge where the line is high and the line is not active. On exception return, a line that is still high becomes pending again.
- R11: A set-pending write ORs its mask into the pending bits and a clear-pending write removes its mask. A capture in the same cycle as a clear of that bit leaves it pending.
- R12: `core_excnum` is 16 plus the line index for an external line, 2 for the non-maskable line, and 0 with `core_prio` 0 when `core_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | External request lines |
| nmi_in | input | 1 | Non-maskable request, edge captured |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| core_req | output | 1 | An interrupt is offered to the core |
| core_excnum | output | 6 | Exception number of the offer |
| core_prio | output | 2 | Priority of the offer |
| core_ack | input | 1 | Core accepts the current offer |
| core_eret | input | 1 | Core returns from the current handler |

## Verification
The assertions assume a well-behaved core:
- `core_ack` is raised only while `core_req` is high.
- `core_eret` is raised only while a handler is active, and never in the same cycle as `core_ack`.
- Software does not rewrite the priority of a line while that line is active.

Under those conditions, the offered priority is always strictly more urgent than the running one, and an accept always adds exactly one active line. The stimulus follows these rules: it pulses accept only after observing an offer, returns only from handlers it has entered, and changes priorities only while nothing is active.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
    localparam int PRIO_W      = 2;
    localparam int EXC_W       = 6;
    localparam int REG_ADDR_W  = 4;
    localparam int REG_DATA_W  = 32;
    localparam int PRIO_PER_WD = REG_DATA_W / PRIO_W;

    localparam logic [EXC_W-1:0] EXC_NMI      = 6'd2;
    localparam logic [EXC_W-1:0] EXC_EXT_BASE = 6'd16;

    localparam logic [REG_ADDR_W-1:0] A_ENABLE  = 4'd0;
    localparam logic [REG_ADDR_W-1:0] A_SETPEND = 4'd1;
    localparam logic [REG_ADDR_W-1:0] A_CLRPEND = 4'd2;
    localparam logic [REG_ADDR_W-1:0] A_ACTIVE  = 4'd3;
    localparam logic [REG_ADDR_W-1:0] A_MODE    = 4'd4;
    localparam logic [REG_ADDR_W-1:0] A_PRIO0   = 4'd8;
    localparam logic [REG_ADDR_W-1:0] A_PRIO1   = 4'd9;

    typedef enum logic [1:0] {
        ST_QUIET     = 2'd0,
        ST_OFFER_IRQ = 2'd1,
        ST_OFFER_NMI = 2'd2
    } offer_state_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import pvic_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [REG_ADDR_W-1:0]          addr,
    input  logic [REG_DATA_W-1:0]          wdata,
    input  logic [NUM_LINES-1:0]           pend,
    input  logic [NUM_LINES-1:0]           active,
    output logic [NUM_LINES-1:0]           enable,
    output logic [NUM_LINES-1:0]           pulse_mode,
    output logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    output logic [NUM_LINES-1:0]           sw_set,
    output logic [NUM_LINES-1:0]           sw_clr,
    output logic [REG_DATA_W-1:0]          rdata
);
    localparam int IMG_W = 2 * REG_DATA_W;

    logic [IMG_W-1:0]      prio_img;
    logic [REG_DATA_W-1:0] rd_mux;

    // Per-line priority fields; absent lines read as zero.
    for (genvar g = 0; g < REG_DATA_W; g++) begin : g_prio
        localparam int WORD = g / PRIO_PER_WD;
        localparam int LSB  = PRIO_W * (g % PRIO_PER_WD);
        localparam logic [REG_ADDR_W-1:0] MY_ADDR = (WORD == 0) ? A_PRIO0 : A_PRIO1;
        if (g < NUM_LINES) begin : g_live
            logic [PRIO_W-1:0] prio_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    prio_r <= '0;
                else if (wr_en && addr == MY_ADDR)
                    prio_r <= wdata[LSB +: PRIO_W];
            end
            assign prio[g] = prio_r;
            assign prio_img[PRIO_W*g +: PRIO_W] = prio_r;
        end else begin : g_absent
            assign prio_img[PRIO_W*g +: PRIO_W] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable     <= '0;
            pulse_mode <= '0;
        end else if (wr_en) begin
            if (addr == A_ENABLE) enable     <= wdata[NUM_LINES-1:0];
            if (addr == A_MODE)   pulse_mode <= wdata[NUM_LINES-1:0];
        end
    end

    assign sw_set = (wr_en && addr == A_SETPEND) ? wdata[NUM_LINES-1:0] : '0;
    assign sw_clr = (wr_en && addr == A_CLRPEND) ? wdata[NUM_LINES-1:0] : '0;

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            A_ENABLE:             rd_mux = REG_DATA_W'(enable);
            A_SETPEND, A_CLRPEND: rd_mux = REG_DATA_W'(pend);
            A_ACTIVE:             rd_mux = REG_DATA_W'(active);
            A_MODE:               rd_mux = REG_DATA_W'(pulse_mode);
            A_PRIO0:              rd_mux = prio_img[REG_DATA_W-1:0];
            A_PRIO1:              rd_mux = prio_img[IMG_W-1:REG_DATA_W];
            default:              rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_mux;
    end
endmodule

// File: rtl/irq_track.sv
module irq_track #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] pulse_mode,
    input  logic [NUM_LINES-1:0] sw_set,
    input  logic [NUM_LINES-1:0] sw_clr,
    input  logic [NUM_LINES-1:0] ack_line,
    input  logic [NUM_LINES-1:0] ret_line,
    input  logic                 nmi_in,
    input  logic                 ack_nmi,
    input  logic                 ret_nmi,
    output logic [NUM_LINES-1:0] pend,
    output logic [NUM_LINES-1:0] active,
    output logic                 nmi_pend,
    output logic                 nmi_active
);
    logic [NUM_LINES-1:0] irq_q;
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] active_nx;
    logic [NUM_LINES-1:0] capture;
    logic [NUM_LINES-1:0] pend_nx;
    logic                 nmi_q;

    assign rise      = irq_in & ~irq_q;
    assign active_nx = (active | ack_line) & ~ret_line;
    // Level lines are masked while (or about to be) in service.
    assign capture   = (pulse_mode & rise) | (~pulse_mode & irq_in & ~active_nx);
    // Capture and software set are applied after the clears: set wins.
    assign pend_nx   = (pend & ~ack_line & ~sw_clr) | sw_set | capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q      <= '0;
            pend       <= '0;
            active     <= '0;
            nmi_q      <= 1'b0;
            nmi_pend   <= 1'b0;
            nmi_active <= 1'b0;
        end else begin
            irq_q      <= irq_in;
            pend       <= pend_nx;
            active     <= active_nx;
            nmi_q      <= nmi_in;
            nmi_pend   <= (nmi_pend & ~ack_nmi) | (nmi_in & ~nmi_q);
            nmi_active <= (nmi_active | ack_nmi) & ~ret_nmi;
        end
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import pvic_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0]             pend,
    input  logic [NUM_LINES-1:0]             enable,
    input  logic [NUM_LINES-1:0]             active,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    input  logic                             nmi_pend,
    input  logic                             nmi_active,
    output logic                             take_nmi,
    output logic                             take_irq,
    output logic [IDX_W-1:0]                 take_idx,
    output logic [PRIO_W-1:0]                take_prio,
    output logic [PRIO_W:0]                  run_prio,
    output logic [NUM_LINES-1:0]             ret_line
);
    localparam logic [PRIO_W:0] RUN_NONE = (PRIO_W+1)'(1 << PRIO_W);

    logic              found;
    logic [PRIO_W-1:0] best_p;
    logic [IDX_W-1:0]  best_i;
    logic              act_found;
    logic [IDX_W-1:0]  act_i;

    // Descending scans with <= leave the lowest index on ties:
    // a fixed-depth comparator chain, no data-dependent cycles.
    always_comb begin
        found  = 1'b0;
        best_p = '0;
        best_i = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (pend[i] && enable[i] && (!found || prio[i] <= best_p)) begin
                found  = 1'b1;
                best_p = prio[i];
                best_i = IDX_W'(i);
            end
        end
    end

    always_comb begin
        act_found = 1'b0;
        run_prio  = RUN_NONE;
        act_i     = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (active[i] && {1'b0, prio[i]} <= run_prio) begin
                act_found = 1'b1;
                run_prio  = {1'b0, prio[i]};
                act_i     = IDX_W'(i);
            end
        end
    end

    always_comb begin
        ret_line = '0;
        if (act_found) ret_line[act_i] = 1'b1;
    end

    assign take_nmi  = nmi_pend && !nmi_active;
    assign take_irq  = found && !nmi_active && ({1'b0, best_p} < run_prio);
    assign take_idx  = best_i;
    assign take_prio = best_p;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pvic_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  irq_in,
    input  logic                  nmi_in,
    input  logic                  reg_wr_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    output logic                  core_req,
    output logic [EXC_W-1:0]      core_excnum,
    output logic [PRIO_W-1:0]     core_prio,
    input  logic                  core_ack,
    input  logic                  core_eret
);
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [NUM_LINES-1:0]             enable;
    logic [NUM_LINES-1:0]             pulse_mode;
    logic [NUM_LINES-1:0][PRIO_W-1:0] prio;
    logic [NUM_LINES-1:0]             sw_set;
    logic [NUM_LINES-1:0]             sw_clr;
    logic [NUM_LINES-1:0]             pend;
    logic [NUM_LINES-1:0]             line_active;
    logic                             nmi_pend;
    logic                             nmi_active;
    logic                             take_nmi;
    logic                             take_irq;
    logic [IDX_W-1:0]                 take_idx;
    logic [PRIO_W-1:0]                take_prio;
    logic [PRIO_W:0]                  run_prio;
    logic [NUM_LINES-1:0]             ret_pick;
    logic [NUM_LINES-1:0]             ack_line;
    logic [NUM_LINES-1:0]             ret_line;
    logic                             ack_nmi;
    logic                             ret_nmi;

    offer_state_e      state, state_nx;
    logic              load_offer;
    logic [IDX_W-1:0]  offer_idx;
    logic [PRIO_W-1:0] offer_prio;

    irq_cfg_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .pend       (pend),
        .active     (line_active),
        .enable     (enable),
        .pulse_mode (pulse_mode),
        .prio       (prio),
        .sw_set     (sw_set),
        .sw_clr     (sw_clr),
        .rdata      (reg_rdata)
    );

    irq_track #(.NUM_LINES(NUM_LINES)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .pulse_mode (pulse_mode),
        .sw_set     (sw_set),
        .sw_clr     (sw_clr),
        .ack_line   (ack_line),
        .ret_line   (ret_line),
        .nmi_in     (nmi_in),
        .ack_nmi    (ack_nmi),
        .ret_nmi    (ret_nmi),
        .pend       (pend),
        .active     (line_active),
        .nmi_pend   (nmi_pend),
        .nmi_active (nmi_active)
    );

    irq_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick (
        .pend       (pend),
        .enable     (enable),
        .active     (line_active),
        .prio       (prio),
        .nmi_pend   (nmi_pend),
        .nmi_active (nmi_active),
        .take_nmi   (take_nmi),
        .take_irq   (take_irq),
        .take_idx   (take_idx),
        .take_prio  (take_prio),
        .run_prio   (run_prio),
        .ret_line   (ret_pick)
    );

    // Handshake decode toward the tracking logic.
    always_comb begin
        ack_line = '0;
        if (state == ST_OFFER_IRQ && core_ack) ack_line[offer_idx] = 1'b1;
    end
    assign ack_nmi  = (state == ST_OFFER_NMI) && core_ack;
    assign ret_nmi  = core_eret && nmi_active;
    assign ret_line = (core_eret && !nmi_active) ? ret_pick : '0;

    // State register and offer latch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_QUIET;
            offer_idx  <= '0;
            offer_prio <= '0;
        end else begin
            state <= state_nx;
            if (load_offer) begin
                offer_idx  <= take_idx;
                offer_prio <= take_prio;
            end
        end
    end

    // Next-state logic: raise, retarget, escalate, withdraw, accept.
    always_comb begin
        state_nx   = state;
        load_offer = 1'b0;
        unique case (state)
            ST_QUIET: begin
                if (take_nmi) begin
                    state_nx = ST_OFFER_NMI;
                end else if (take_irq) begin
                    state_nx   = ST_OFFER_IRQ;
                    load_offer = 1'b1;
                end
            end
            ST_OFFER_IRQ: begin
                if (core_ack) begin
                    state_nx = ST_QUIET;
                end else if (take_nmi) begin
                    state_nx = ST_OFFER_NMI;
                end else if (take_irq) begin
                    state_nx   = ST_OFFER_IRQ;
                    load_offer = 1'b1;
                end else begin
                    state_nx = ST_QUIET;
                end
            end
            ST_OFFER_NMI: begin
                if (core_ack) state_nx = ST_QUIET;
            end
            default: state_nx = ST_QUIET;
        endcase
    end

    // Output decode.
    always_comb begin
        core_req    = 1'b0;
        core_excnum = '0;
        core_prio   = '0;
        unique case (state)
            ST_QUIET: ;
            ST_OFFER_IRQ: begin
                core_req    = 1'b1;
                core_excnum = EXC_EXT_BASE + EXC_W'(offer_idx);
                core_prio   = offer_prio;
            end
            ST_OFFER_NMI: begin
                core_req    = 1'b1;
                core_excnum = EXC_NMI;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
    import pvic_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 core_req,
    input logic                 core_ack,
    input logic [EXC_W-1:0]     core_excnum,
    input logic [PRIO_W-1:0]    core_prio,
    input logic [NUM_LINES-1:0] active,
    input logic                 nmi_active,
    input logic [PRIO_W:0]      run_prio
);
    localparam int EXC_TOP = 16 + NUM_LINES;

    assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !core_req |-> (core_excnum == '0 && core_prio == '0));

    assert_excnum_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> (core_excnum == EXC_NMI ||
                      (int'(core_excnum) >= 16 && int'(core_excnum) < EXC_TOP)));

    assert_nmi_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && core_excnum == EXC_NMI) |-> core_prio == '0);

    assert_nmi_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && core_excnum != EXC_NMI) |-> !nmi_active);

    assert_strict_preempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && core_excnum != EXC_NMI) |-> ({1'b0, core_prio} < run_prio));

    assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && core_ack) |=> !core_req);

    assert_ack_activates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && core_ack && core_excnum != EXC_NMI) |=>
            ($countones(active) == $countones($past(active)) + 1));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_req    (core_req),
    .core_ack    (core_ack),
    .core_excnum (core_excnum),
    .core_prio   (core_prio),
    .active      (line_active),
    .nmi_active  (nmi_active),
    .run_prio    (run_prio)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          nmi_in = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          core_req;
    logic [5:0]    core_excnum;
    logic [1:0]    core_prio;
    logic          core_ack = 1'b0;
    logic          core_eret = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    prio_irq_ctrl #(.NUM_LINES(N)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .core_req(core_req), .core_excnum(core_excnum),
        .core_prio(core_prio), .core_ack(core_ack), .core_eret(core_eret)
    );

    typedef struct packed {
        logic [7:0]  en;
        logic [15:0] pr;
        logic [7:0]  pd;
        logic        req;
        logic [5:0]  num;
        logic [1:0]  pri;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{8'hFF, 16'h0000, 8'h01, 1'b1, 6'd16, 2'd0},
        '{8'hFF, 16'h0000, 8'h0C, 1'b1, 6'd18, 2'd0},
        '{8'hFF, 16'h040C, 8'h22, 1'b1, 6'd21, 2'd1},
        '{8'hDF, 16'h040C, 8'h22, 1'b1, 6'd17, 2'd3},
        '{8'h00, 16'h0000, 8'hFF, 1'b0, 6'd0,  2'd0},
        '{8'hFF, 16'hFFFF, 8'h80, 1'b1, 6'd23, 2'd3},
        '{8'hFF, 16'hBFFF, 8'hF0, 1'b1, 6'd23, 2'd2},
        '{8'h0F, 16'h0000, 8'hF0, 1'b0, 6'd0,  2'd0},
        '{8'hFF, 16'hEFBF, 8'h48, 1'b1, 6'd19, 2'd2}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        tick();
        d = reg_rdata;
    endtask

    task automatic ack();
        core_ack = 1'b1; tick(); core_ack = 1'b0;
    endtask

    task automatic eret();
        core_eret = 1'b1; tick(); core_eret = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        tick(); tick();
        // R1: reset state
        check("R1 req", 32'(core_req), 32'd0);
        check("R1 excnum", 32'(core_excnum), 32'd0);
        rst_n = 1'b1;
        tick();
        rd(4'd0, rv); check("R1 enable", rv, 32'd0);
        rd(4'd8, rv); check("R1 prio", rv, 32'd0);

        // R2: readback, unused bits zero
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd4, rv); check("R2 mode readback", rv, 32'h0000_00FF);
        wr(4'd4, 32'h0);

        // Vector table: R3 selection, R6 latency, R12 encoding
        for (int v = 0; v < 9; v++) begin
            wr(4'd0, 32'(VEC[v].en));
            wr(4'd8, 32'(VEC[v].pr));
            wr(4'd1, 32'(VEC[v].pd));
            check("R6 not before second edge", 32'(core_req), 32'd0);
            tick();
            check("R3 req", 32'(core_req), 32'(VEC[v].req));
            check("R12 excnum", 32'(core_excnum), 32'(VEC[v].num));
            check("R3 prio", 32'(core_prio), 32'(VEC[v].pri));
            wr(4'd2, 32'hFF);
            tick();
        end
        rd(4'd8, rv); check("R2 prio word 0", rv, 32'h0000_EFBF);
        rd(4'd9, rv); check("R2 prio word 1", rv, 32'd0);

        // R4: non-maskable
        wr(4'd0, 32'hFF); wr(4'd8, 32'h0); wr(4'd1, 32'h01);
        tick();
        check("R4 line0 offered", 32'(core_excnum), 32'd16);
        nmi_in = 1'b1; tick(); nmi_in = 1'b0; tick();
        check("R4 nmi num", 32'(core_excnum), 32'd2);
        check("R4 nmi prio", 32'(core_prio), 32'd0);
        ack();
        check("R7 drop after nmi accept", 32'(core_req), 32'd0);
        tick();
        check("R4 nothing during nmi", 32'(core_req), 32'd0);
        eret(); tick();
        check("R8 line0 after nmi return", 32'(core_excnum), 32'd16);
        ack();
        rd(4'd3, rv); check("R7 active line0", rv, 32'h01);
        eret();
        rd(4'd3, rv); check("R8 none active", rv, 32'h00);

        // R5 / R7 / R8: preemption
        wr(4'd4, 32'h07); wr(4'd8, 32'h1A); wr(4'd1, 32'h01);
        tick();
        check("R5 line0 offered", 32'(core_excnum), 32'd16);
        ack();
        check("R7 drop after accept", 32'(core_req), 32'd0);
        wr(4'd1, 32'h02); tick();
        check("R5 equal prio held", 32'(core_req), 32'd0);
        wr(4'd1, 32'h04); tick();
        check("R5 preempt num", 32'(core_excnum), 32'd18);
        check("R5 preempt prio", 32'(core_prio), 32'd1);
        ack();
        rd(4'd3, rv); check("R7 nested active", rv, 32'h05);
        eret();
        rd(4'd3, rv); check("R8 inner returned", rv, 32'h01);
        check("R5 still blocked", 32'(core_req), 32'd0);
        eret(); tick();
        check("R8 line1 after return", 32'(core_excnum), 32'd17);
        ack(); eret();
        rd(4'd3, rv); check("R8 all returned", rv, 32'h00);

        // R9: pulse capture
        irq_in[0] = 1'b1; tick(); irq_in[0] = 1'b0; tick();
        check("R9 pulse offered", 32'(core_excnum), 32'd16);
        rd(4'd1, rv); check("R9 pulse held", rv, 32'h01);
        ack();
        irq_in[0] = 1'b1; tick(); irq_in[0] = 1'b0; tick();
        check("R9 no self preempt", 32'(core_req), 32'd0);
        rd(4'd1, rv); check("R9 repend while active", rv, 32'h01);
        eret(); tick();
        check("R9 served after return", 32'(core_excnum), 32'd16);
        ack(); eret();

        // R10: level capture
        irq_in[3] = 1'b1; tick(); tick();
        check("R10 level offered", 32'(core_excnum), 32'd19);
        ack();
        rd(4'd1, rv); check("R10 masked while active", rv, 32'h00);
        eret(); tick();
        check("R10 repend on return", 32'(core_excnum), 32'd19);
        irq_in[3] = 1'b0;
        ack(); eret(); tick();
        check("R10 no repend when low", 32'(core_req), 32'd0);
        rd(4'd1, rv); check("R10 pending empty", rv, 32'h00);

        // R11: set wins over clear; R3 disabled lines keep pending
        wr(4'd0, 32'h0); wr(4'd4, 32'h17);
        reg_wr_en = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h10; irq_in[4] = 1'b1;
        tick();
        reg_wr_en = 1'b0; irq_in[4] = 1'b0;
        rd(4'd1, rv); check("R11 capture beats clear", rv, 32'h10);
        check("R3 disabled not offered", 32'(core_req), 32'd0);
        wr(4'd2, 32'h10);
        rd(4'd1, rv); check("R11 clear mask", rv, 32'h00);
        wr(4'd1, 32'h30);
        rd(4'd1, rv); check("R11 set mask", rv, 32'h30);
        wr(4'd2, 32'hFF);
        rd(4'd1, rv); check("R11 clear all", rv, 32'h00);

        summary();
    end
endmodule